// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block is the digital heart of a synchronous buck half-bridge driver. It sees a PWM command that an analog front end has already sorted into three levels (high, low, high-impedance), a light-load mode input sorted into three levels (low, high, floating), a zero-current flag from the inductor sense, one feedback flag per gate saying that gate has dropped below its turn-on level, and a supply-good flag. From these it drives the enables for the high-side and low-side gates.

A gate is switched on only after the opposite gate's feedback, resynchronised through two flip-flops, has stayed low for a fixed number of clock cycles, so the dead time adapts to the real gate discharge instead of a fixed guess. A high-impedance PWM level held past a hold-off window switches both gates off. When the mode input is low, a zero-current flag ends the low-side conduction until the next PWM high. When both inputs float, the block parks in a low-power shutdown state and needs a fixed exit latency to leave it. A low supply-good flag forces both gates off at once. All timings are parameters in system clock cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: PWM code 2'b01 (high) leads to the low-side enable being off and then the high-side enable on; code 2'b00 (low) leads to the high-side enable off and then the low-side enable on; codes 2'b10 and 2'b11 mean high-impedance.
- R2: A high-impedance PWM level sampled on HOLD_CYC consecutive clock edges moves the block to the idle state with both enables off; a shorter excursion leaves state and enables unchanged.
- R3: The two enables are never high together, and a gate turns on only after the opposite gate's synchronised feedback has been low on DLY_CYC consecutive edges; feedback stuck high keeps the gate off.
- R4: Once the high-side enable is on it stays on for at least MIN_ON_CYC cycles even if PWM returns low earlier.
- R5: With mode code 2'b00 (emulation allowed), a zero-current flag during low-side conduction switches the low-side enable off and keeps both enables off until PWM is high.
- R6: With mode code 2'b01 (forced continuous) or a floating mode code (2'b10, 2'b11) the zero-current flag has no effect on the low-side enable.
- R7: A mode change to forced continuous while low-side conduction is parked by emulation resumes the low-side sequence on the next clock edge, without any PWM edge.
- R8: PWM and mode both high-impedance on a clock edge put the block in shutdown with both enables off; after they stop both floating, the block stays off for EXIT_CYC further edges before returning to idle.
- R9: While supply-good is low both enables are low in the same cycle, and the block returns to idle at the next edge.
- R10: From reset or after supply-good returns, both enables stay off in idle until a valid PWM high or low is seen.
- R11: The state output encodes idle 0, high-side arm 1, high-side on 2, low-side arm 3, low-side on 4, emulation park 5, shutdown 6, shutdown exit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 1x high-impedance |
| mode_lvl | input | 2 | Decoded mode level: 00 emulation allowed, 01 forced continuous, 1x floating |
| zero_cur | input | 1 | Inductor zero-current crossing flag |
| hs_fb_low | input | 1 | High-side gate below turn-on level (asynchronous) |
| ls_fb_low | input | 1 | Low-side gate below turn-on level (asynchronous) |
| supply_ok | input | 1 | Supply good; low clamps both gates |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| state_o | output | 3 | Current sequencer state (debug) |

## Verification
The supply clamp acts in the same cycle as supply-good falls, so it is sampled half a clock after the input moves; every other result follows one clock edge after the deciding input, while feedback changes take two further edges to pass the synchroniser and DLY_CYC edges of counting before a gate turns on. A behavioural model in the bench advances on the same edges from the same sampled inputs, and both enables and the state output are compared at every falling clock edge, when the design's registers have settled and no stimulus is moving. Directed checks are placed on the cycle where the hold-off, minimum on-time, emulation and shutdown-exit counts expire, and a pseudo-random sweep exercises the interlock.

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int HOLD_CYC   = 8,
  parameter int DLY_CYC    = 2,
  parameter int MIN_ON_CYC = 4,
  parameter int EXIT_CYC   = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic [1:0] mode_lvl,
  input  logic       zero_cur,
  input  logic       hs_fb_low,
  input  logic       ls_fb_low,
  input  logic       supply_ok,
  output logic       hs_en,
  output logic       ls_en,
  output logic [2:0] state_o
);
  localparam int TW = $clog2(HOLD_CYC + DLY_CYC + MIN_ON_CYC + EXIT_CYC + 2);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] HOLD_TOP  = TW'(HOLD_CYC);
  localparam logic [TW-1:0] DLY_LAST  = TW'(DLY_CYC - 1);
  localparam logic [TW-1:0] ON_LAST   = TW'(MIN_ON_CYC - 1);
  localparam logic [TW-1:0] ON_TOP    = TW'(MIN_ON_CYC);
  localparam logic [TW-1:0] EXIT_LAST = TW'(EXIT_CYC - 1);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_HS_ARM = 3'd1, ST_HS_ON = 3'd2, ST_LS_ARM = 3'd3,
    ST_LS_ON = 3'd4, ST_PARK = 3'd5, ST_SHDN = 3'd6, ST_WAKE = 3'd7
  } st_t;

  st_t st, st_n;
  logic [TW-1:0] tmr, tmr_n, zcnt;
  logic [1:0] hs_sync, ls_sync;
  logic hs_low_s, ls_low_s;

  wire pwm_z   = pwm_lvl[1];
  wire pwm_hi  = pwm_lvl == 2'b01;
  wire mode_z  = mode_lvl[1];
  wire emul_ok = mode_lvl == 2'b00;

  assign hs_low_s = hs_sync[1];
  assign ls_low_s = ls_sync[1];
  assign hs_en    = supply_ok && (st == ST_HS_ON);
  assign ls_en    = supply_ok && (st == ST_LS_ON);
  assign state_o  = st;

  always_comb begin
    st_n  = st;
    tmr_n = tmr;
    if (!supply_ok) begin
      st_n = ST_IDLE; tmr_n = '0;
    end else if (pwm_z && mode_z) begin
      st_n = ST_SHDN; tmr_n = '0;
    end else if (st == ST_SHDN) begin
      st_n = ST_WAKE; tmr_n = '0;
    end else if (st == ST_WAKE) begin
      if (tmr == EXIT_LAST) begin st_n = ST_IDLE; tmr_n = '0; end
      else tmr_n = tmr + 1'b1;
    end else if (pwm_z) begin
      if (zcnt == HOLD_LAST) begin st_n = ST_IDLE; tmr_n = '0; end
    end else begin
      case (st)
        ST_IDLE: begin
          st_n = pwm_hi ? ST_HS_ARM : ST_LS_ARM; tmr_n = '0;
        end
        ST_HS_ARM: begin
          if (!pwm_hi) begin st_n = ST_LS_ARM; tmr_n = '0; end
          else if (!ls_low_s) tmr_n = '0;
          else if (tmr == DLY_LAST) begin st_n = ST_HS_ON; tmr_n = '0; end
          else tmr_n = tmr + 1'b1;
        end
        ST_HS_ON: begin
          if (!pwm_hi && tmr >= ON_LAST) begin st_n = ST_LS_ARM; tmr_n = '0; end
          else if (tmr != ON_TOP) tmr_n = tmr + 1'b1;
        end
        ST_LS_ARM: begin
          if (pwm_hi) begin st_n = ST_HS_ARM; tmr_n = '0; end
          else if (!hs_low_s) tmr_n = '0;
          else if (tmr == DLY_LAST) begin st_n = ST_LS_ON; tmr_n = '0; end
          else tmr_n = tmr + 1'b1;
        end
        ST_LS_ON: begin
          if (pwm_hi) begin st_n = ST_HS_ARM; tmr_n = '0; end
          else if (emul_ok && zero_cur) begin st_n = ST_PARK; tmr_n = '0; end
        end
        ST_PARK: begin
          if (pwm_hi) begin st_n = ST_HS_ARM; tmr_n = '0; end
          else if (!emul_ok) begin st_n = ST_LS_ARM; tmr_n = '0; end
        end
        default: begin st_n = ST_IDLE; tmr_n = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tmr     <= '0;
      zcnt    <= '0;
      hs_sync <= '0;
      ls_sync <= '0;
    end else begin
      st      <= st_n;
      tmr     <= tmr_n;
      hs_sync <= {hs_sync[0], hs_fb_low};
      ls_sync <= {ls_sync[0], ls_fb_low};
      if (!pwm_z) zcnt <= '0;
      else if (zcnt != HOLD_TOP) zcnt <= zcnt + 1'b1;
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));
  assert_hs_waits_ls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(ls_low_s));
  assert_ls_waits_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(hs_low_s));
  assert_hold_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && pwm_z && !mode_z && zcnt == HOLD_LAST && st != ST_SHDN && st != ST_WAKE)
      |=> st == ST_IDLE);
  assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HS_ON && supply_ok && pwm_lvl == 2'b00 && tmr < ON_LAST) |=> st == ST_HS_ON);
  assert_ccm_keeps_ls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LS_ON && supply_ok && !emul_ok && pwm_lvl == 2'b00) |=> st == ST_LS_ON);
  assert_enter_shdn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && pwm_z && mode_z) |=> st == ST_SHDN);
  assert_supply_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> st == ST_IDLE);
endmodule

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;
  localparam int HOLD = 8, DLY = 2, MINON = 4, EXITC = 250;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pwm_lvl = 2'b10, mode_lvl = 2'b01;
  logic zero_cur = 1'b0, hs_fb_low = 1'b1, ls_fb_low = 1'b1, supply_ok = 1'b1;
  logic hs_en, ls_en;
  logic [2:0] state_o;
  logic ls_stuck = 1'b0;

  int checks = 0, failures = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  hb_gate_seq #(.HOLD_CYC(HOLD), .DLY_CYC(DLY), .MIN_ON_CYC(MINON), .EXIT_CYC(EXITC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .mode_lvl(mode_lvl), .zero_cur(zero_cur),
    .hs_fb_low(hs_fb_low), .ls_fb_low(ls_fb_low), .supply_ok(supply_ok),
    .hs_en(hs_en), .ls_en(ls_en), .state_o(state_o));

  // behavioural reference
  int m_st = 0, m_t = 0, m_z = 0;
  bit m_h1 = 0, m_h2 = 0, m_l1 = 0, m_l2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_z = 0; m_h1 = 0; m_h2 = 0; m_l1 = 0; m_l2 = 0;
    end else begin
      int ns, nt;
      bit pz, ph, mz, mlo;
      pz = pwm_lvl[1]; ph = (pwm_lvl == 2'b01);
      mz = mode_lvl[1]; mlo = (mode_lvl == 2'b00);
      ns = m_st; nt = m_t;
      if (!supply_ok) begin ns = 0; nt = 0; end
      else if (pz && mz) begin ns = 6; nt = 0; end
      else if (m_st == 6) begin ns = 7; nt = 0; end
      else if (m_st == 7) begin
        if (m_t + 1 >= EXITC) begin ns = 0; nt = 0; end else nt = m_t + 1;
      end else if (pz) begin
        if (m_z + 1 == HOLD) begin ns = 0; nt = 0; end
      end else if (m_st == 0) begin
        ns = ph ? 1 : 3; nt = 0;
      end else if (m_st == 1 || m_st == 3) begin
        bit want_hi, other_low;
        want_hi = (m_st == 1);
        other_low = want_hi ? m_l2 : m_h2;
        if (ph != want_hi) begin ns = ph ? 1 : 3; nt = 0; end
        else if (!other_low) nt = 0;
        else if (m_t + 1 >= DLY) begin ns = want_hi ? 2 : 4; nt = 0; end
        else nt = m_t + 1;
      end else if (m_st == 2) begin
        if (!ph && m_t + 1 >= MINON) begin ns = 3; nt = 0; end
        else if (m_t < MINON) nt = m_t + 1;
      end else if (m_st == 4) begin
        if (ph) begin ns = 1; nt = 0; end
        else if (mlo && zero_cur) begin ns = 5; nt = 0; end
      end else if (m_st == 5) begin
        if (ph) begin ns = 1; nt = 0; end
        else if (!mlo) begin ns = 3; nt = 0; end
      end
      m_z = pz ? ((m_z < HOLD) ? m_z + 1 : HOLD) : 0;
      m_h2 = m_h1; m_h1 = hs_fb_low;
      m_l2 = m_l1; m_l1 = ls_fb_low;
      m_st = ns; m_t = nt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_h, exp_l;
      exp_h = supply_ok && (m_st == 2);
      exp_l = supply_ok && (m_st == 4);
      checks++;
      if (hs_en !== exp_h || ls_en !== exp_l || state_o !== 3'(m_st)) begin
        failures++;
        $display("FAIL %s cycle compare: act hs=%b ls=%b st=%0d exp hs=%b ls=%b st=%0d",
                 cur_req, hs_en, ls_en, state_o, exp_h, exp_l, m_st);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      hs_fb_low = !hs_en;
      ls_fb_low = ls_stuck ? 1'b0 : !ls_en;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic peek(output logic h, output logic l, output logic [2:0] s);
    @(negedge clk); #1;
    h = hs_en; l = ls_en; s = state_o;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  initial begin
    logic h, l;
    logic [2:0] s;
    int lcg;
    step(3);
    @(posedge clk); #5; rst_n = 1'b1;
    peek(h, l, s);
    chk("R11 reset state", s, 0);
    chk("R10 reset gates", {h, l}, 0);

    cur_req = "R10";
    step(20);
    peek(h, l, s);
    chk("R10 idle while pwm floats", s, 0);

    cur_req = "R1";
    pwm_lvl = 2'b01; step(12);
    peek(h, l, s);
    chk("R1 pwm high hs on", {h, l}, 2);
    chk("R11 hs on code", s, 2);
    pwm_lvl = 2'b00; step(12);
    peek(h, l, s);
    chk("R1 pwm low ls on", {h, l}, 1);

    cur_req = "R4";
    pwm_lvl = 2'b01;
    for (int i = 0; i < 20 && !hs_en; i++) step(1);
    pwm_lvl = 2'b00; step(1);
    peek(h, l, s);
    chk("R4 hs stretched", h, 1);
    step(12);
    peek(h, l, s);
    chk("R4 after stretch ls on", l, 1);

    cur_req = "R2";
    pwm_lvl = 2'b10; step(HOLD - 1);
    peek(h, l, s);
    chk("R2 short float keeps ls", l, 1);
    pwm_lvl = 2'b00; step(2);
    pwm_lvl = 2'b11; step(HOLD);
    peek(h, l, s);
    chk("R2 hold-off idle", s, 0);
    chk("R2 hold-off gates off", {h, l}, 0);
    pwm_lvl = 2'b00; step(10);

    cur_req = "R3";
    ls_stuck = 1'b1; pwm_lvl = 2'b01; step(12);
    peek(h, l, s);
    chk("R3 stuck feedback holds hs off", h, 0);
    ls_stuck = 1'b0; step(8);
    peek(h, l, s);
    chk("R3 hs on after release", h, 1);

    cur_req = "R5";
    mode_lvl = 2'b00; pwm_lvl = 2'b00; step(12);
    zero_cur = 1'b1; step(1); zero_cur = 1'b0; step(6);
    peek(h, l, s);
    chk("R5 emulation park", s, 5);
    chk("R5 park gates off", {h, l}, 0);
    pwm_lvl = 2'b01; step(10);
    peek(h, l, s);
    chk("R5 pwm high leaves park", h, 1);

    cur_req = "R6";
    pwm_lvl = 2'b00; mode_lvl = 2'b01; step(12);
    zero_cur = 1'b1; step(5);
    peek(h, l, s);
    chk("R6 forced ccm ignores zero current", l, 1);
    mode_lvl = 2'b10; step(5);
    peek(h, l, s);
    chk("R6 floating mode ignores zero current", l, 1);
    zero_cur = 1'b0;

    cur_req = "R7";
    mode_lvl = 2'b00; zero_cur = 1'b1; step(1); zero_cur = 1'b0; step(3);
    mode_lvl = 2'b01; step(1);
    peek(h, l, s);
    chk("R7 mode change resumes at once", s, 3);
    step(8);

    cur_req = "R8";
    pwm_lvl = 2'b10; mode_lvl = 2'b10; step(1);
    peek(h, l, s);
    chk("R8 shutdown entry", s, 6);
    step(10);
    pwm_lvl = 2'b00; mode_lvl = 2'b01; step(EXITC);
    peek(h, l, s);
    chk("R8 still waking", s, 7);
    step(1);
    peek(h, l, s);
    chk("R8 wake done idle", s, 0);
    step(10);
    peek(h, l, s);
    chk("R8 switching resumes", l, 1);

    cur_req = "R9";
    pwm_lvl = 2'b01; step(12);
    @(posedge clk); #5; supply_ok = 1'b0;
    @(negedge clk); #1;
    chk("R9 clamp same cycle", {hs_en, ls_en}, 0);
    step(5);
    cur_req = "R10";
    pwm_lvl = 2'b10; supply_ok = 1'b1; step(4);
    peek(h, l, s);
    chk("R10 idle after supply return", s, 0);
    pwm_lvl = 2'b01; step(10);
    peek(h, l, s);
    chk("R10 switching after valid pwm", h, 1);

    cur_req = "R3";
    lcg = 12345;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 1103515245 + 12345;
      if (lcg[20:18] == 3'd0) pwm_lvl = lcg[17:16];
      if (lcg[26:22] == 5'd0) mode_lvl = lcg[9:8];
      zero_cur = lcg[12] & lcg[13];
      supply_ok = (lcg[30:25] != 6'd0);
      step(1);
    end
    finish_run();
  end
endmodule